// File: doc/BRIEF.md
# Instruction Word Decoder and Control Unit

This block turns one 32-bit instruction word into what a single-cycle 64-bit datapath needs in the same cycle: the two source register numbers, the destination number, a sign-extended 64-bit offset and a set of control strobes. It is purely combinational. A fetch stage drives the word in, and the register file, ALU, data memory and next-PC logic consume the outputs directly.

Four encoding families are recognised, each by a prefix at the top of the word. Register-register arithmetic and memory access use an 11-bit prefix. The compare-against-zero branch uses an 8-bit prefix. The unconditional jump uses a 6-bit prefix. All three prefixes are compared against the same top bits, longest first. A word that matches no prefix leaves every state-changing strobe low, so the datapath treats it as a bubble.

Top module: `instr_decoder`

## Requirements
- R1: Prefixes 10001011000, 11001011000, 10001010000 and 10101010000 in bits [31:21] decode as add, subtract, and, or. Each sets reg_write_o=1 with alu_op_o 0010, 0110, 0000 and 0001 respectively. mem_read_o, mem_write_o, mem_to_reg_o, alu_src_o, branch_o, uncond_o and reg2_sel_o are 0.
- R2: Prefix 11111000010 (load) sets reg_write_o, mem_read_o, mem_to_reg_o and alu_src_o to 1 with alu_op_o=0010. All other strobes are 0.
- R3: Prefix 11111000000 (store) sets mem_write_o, alu_src_o and reg2_sel_o to 1 with alu_op_o=0010. reg_write_o is 0, and rs2_o carries bits [4:0].
- R4: Prefix 10110100 in bits [31:24] (branch if zero) sets branch_o and reg2_sel_o to 1 with alu_op_o=0111 (pass second operand). Write strobes are 0, and rs2_o carries bits [4:0].
- R5: Prefix 000101 in bits [31:26] (jump) sets uncond_o=1 with alu_op_o=0000, and imm_o is bits [25:0] sign-extended to 64 bits. All other strobes are 0.
- R6: rs1_o is always bits [9:5] and rd_o is always bits [4:0]. rs2_o is bits [20:16] whenever reg2_sel_o is 0.
- R7: For load and store, imm_o is bits [20:12] sign-extended to 64 bits. For branch-if-zero it is bits [23:5] sign-extended. For arithmetic and unmatched words it is 0.
- R8: A word matching none of the prefixes drives all strobes to 0 and alu_op_o to 0000.
- R9: mem_read_o and mem_write_o are never both 1, and branch_o and uncond_o are never both 1.
- R10: Bits below a matched prefix never change the decoded strobes or alu_op_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs1_o | output | 5 | First source register number |
| rs2_o | output | 5 | Second source register number |
| rd_o | output | 5 | Destination / data register number |
| imm_o | output | 64 | Sign-extended offset |
| reg_write_o | output | 1 | Register file write enable |
| mem_read_o | output | 1 | Data memory read |
| mem_write_o | output | 1 | Data memory write |
| mem_to_reg_o | output | 1 | Write-back takes memory data |
| alu_src_o | output | 1 | ALU second operand is imm_o |
| alu_op_o | output | 4 | ALU function code |
| branch_o | output | 1 | Conditional branch (taken on zero) |
| uncond_o | output | 1 | Unconditional branch |
| reg2_sel_o | output | 1 | Second read uses bits [4:0] |

## Verification
The hardest cases are words that share most of a prefix with a real instruction but differ in one bit. This matters most where a 6-bit or 8-bit prefix is a subset of the same top bits that the 11-bit prefixes use. Random words almost never land there. The stimulus therefore flips each prefix bit of every valid opcode in turn and fills the remaining bits with a spread of payloads. The bench also walks each opcode under many payloads, including all-zero and all-ones, to cover both signs of every offset and confirm that the payload bits have no effect on the strobes.

// File: rtl/idec_pkg.sv
package idec_pkg;
  typedef enum logic [2:0] {
    CL_NONE, CL_ALU, CL_LOAD, CL_STORE, CL_CBR, CL_JUMP
  } op_class_e;

  typedef struct packed {
    logic       reg_write;
    logic       mem_read;
    logic       mem_write;
    logic       mem_to_reg;
    logic       alu_src;
    logic       branch;
    logic       uncond;
    logic       reg2_sel;
    logic [3:0] alu_op;
  } ctrl_t;

  localparam int unsigned LONG_W  = 11;
  localparam int unsigned MID_W   = 8;
  localparam int unsigned SHORT_W = 6;

  localparam logic [LONG_W-1:0]  OPC_LOAD  = 11'b11111000010;
  localparam logic [LONG_W-1:0]  OPC_STORE = 11'b11111000000;
  localparam logic [LONG_W-1:0]  OPC_ADD   = 11'b10001011000;
  localparam logic [LONG_W-1:0]  OPC_SUB   = 11'b11001011000;
  localparam logic [LONG_W-1:0]  OPC_AND   = 11'b10001010000;
  localparam logic [LONG_W-1:0]  OPC_OR    = 11'b10101010000;
  localparam logic [MID_W-1:0]   OPC_CBR   = 8'b10110100;
  localparam logic [SHORT_W-1:0] OPC_JUMP  = 6'b000101;

  localparam logic [3:0] ALU_AND   = 4'b0000;
  localparam logic [3:0] ALU_OR    = 4'b0001;
  localparam logic [3:0] ALU_ADD   = 4'b0010;
  localparam logic [3:0] ALU_SUB   = 4'b0110;
  localparam logic [3:0] ALU_PASSB = 4'b0111;
endpackage

// File: rtl/idec_match.sv
module idec_match
  import idec_pkg::*;
(
  input  logic [LONG_W-1:0] top_i,
  output op_class_e         cls_o,
  output logic [3:0]        alu_fn_o
);
  logic [MID_W-1:0]   top_mid;
  logic [SHORT_W-1:0] top_short;

  assign top_mid   = top_i[LONG_W-1 -: MID_W];
  assign top_short = top_i[LONG_W-1 -: SHORT_W];

  // longest prefix wins
  always_comb begin
    cls_o    = CL_NONE;
    alu_fn_o = ALU_AND;
    unique case (top_i)
      OPC_LOAD:  begin cls_o = CL_LOAD;  alu_fn_o = ALU_ADD; end
      OPC_STORE: begin cls_o = CL_STORE; alu_fn_o = ALU_ADD; end
      OPC_ADD:   begin cls_o = CL_ALU;   alu_fn_o = ALU_ADD; end
      OPC_SUB:   begin cls_o = CL_ALU;   alu_fn_o = ALU_SUB; end
      OPC_AND:   begin cls_o = CL_ALU;   alu_fn_o = ALU_AND; end
      OPC_OR:    begin cls_o = CL_ALU;   alu_fn_o = ALU_OR;  end
      default: begin
        if (top_mid == OPC_CBR) begin
          cls_o    = CL_CBR;
          alu_fn_o = ALU_PASSB;
        end else if (top_short == OPC_JUMP) begin
          cls_o = CL_JUMP;
        end
      end
    endcase
  end
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
  import idec_pkg::*;
(
  input  op_class_e  cls_i,
  input  logic [3:0] alu_fn_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = alu_fn_i;
    unique case (cls_i)
      CL_ALU:   ctrl_o.reg_write = 1'b1;
      CL_LOAD: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.mem_read   = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.alu_src    = 1'b1;
      end
      CL_STORE: begin
        ctrl_o.mem_write = 1'b1;
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.reg2_sel  = 1'b1;
      end
      CL_CBR: begin
        ctrl_o.branch   = 1'b1;
        ctrl_o.reg2_sel = 1'b1;
      end
      CL_JUMP:  ctrl_o.uncond = 1'b1;
      default:  ctrl_o.alu_op = ALU_AND;
    endcase
  end

  always_comb begin
    AST_MEM_EXCL: assert (!(ctrl_o.mem_read && ctrl_o.mem_write)); // R9
    AST_BR_EXCL: assert (!(ctrl_o.branch && ctrl_o.uncond)); // R9
    AST_LOAD_WB: assert (!ctrl_o.mem_to_reg || (ctrl_o.mem_read && ctrl_o.reg_write)); // R2
  end
endmodule

// File: rtl/idec_imm.sv
module idec_imm
  import idec_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned MEM_W  = 9,
  parameter int unsigned CBR_W  = 19,
  parameter int unsigned JMP_W  = 26,
  parameter int unsigned MEM_LO = 12,
  parameter int unsigned CBR_LO = 5
) (
  input  logic [JMP_W-1:0] low_i,
  input  op_class_e        cls_i,
  output logic [XLEN-1:0]  imm_o
);
  localparam int unsigned MEM_HI = MEM_LO + MEM_W - 1;
  localparam int unsigned CBR_HI = CBR_LO + CBR_W - 1;

  logic [XLEN-1:0] mem_ext, cbr_ext, jmp_ext;

  assign mem_ext = {{(XLEN-MEM_W){low_i[MEM_HI]}}, low_i[MEM_HI:MEM_LO]};
  assign cbr_ext = {{(XLEN-CBR_W){low_i[CBR_HI]}}, low_i[CBR_HI:CBR_LO]};
  assign jmp_ext = {{(XLEN-JMP_W){low_i[JMP_W-1]}}, low_i};

  always_comb begin
    unique case (cls_i)
      CL_LOAD, CL_STORE: imm_o = mem_ext;
      CL_CBR:            imm_o = cbr_ext;
      CL_JUMP:           imm_o = jmp_ext;
      default:           imm_o = '0;
    endcase
  end

  always_comb begin
    AST_CBR_SIGN: assert (cls_i != CL_CBR || imm_o[XLEN-1] == low_i[CBR_HI]); // R7
    AST_JMP_SIGN: assert (cls_i != CL_JUMP || imm_o[XLEN-1] == low_i[JMP_W-1]); // R5
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import idec_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned IW   = 32,
  parameter int unsigned RW   = 5
) (
  input  logic [IW-1:0]   instr_i,
  output logic [RW-1:0]   rs1_o,
  output logic [RW-1:0]   rs2_o,
  output logic [RW-1:0]   rd_o,
  output logic [XLEN-1:0] imm_o,
  output logic            reg_write_o,
  output logic            mem_read_o,
  output logic            mem_write_o,
  output logic            mem_to_reg_o,
  output logic            alu_src_o,
  output logic [3:0]      alu_op_o,
  output logic            branch_o,
  output logic            uncond_o,
  output logic            reg2_sel_o
);
  localparam int unsigned JMP_W  = IW - SHORT_W;
  localparam int unsigned RS1_LO = RW;
  localparam int unsigned RM_LO  = IW - LONG_W - RW;

  op_class_e  cls;
  logic [3:0] alu_fn;
  ctrl_t      ctrl;

  idec_match u_match (
    .top_i   (instr_i[IW-1 -: LONG_W]),
    .cls_o   (cls),
    .alu_fn_o(alu_fn)
  );

  idec_ctrl u_ctrl (
    .cls_i   (cls),
    .alu_fn_i(alu_fn),
    .ctrl_o  (ctrl)
  );

  idec_imm #(.XLEN(XLEN), .JMP_W(JMP_W)) u_imm (
    .low_i(instr_i[JMP_W-1:0]),
    .cls_i(cls),
    .imm_o(imm_o)
  );

  assign rs1_o        = instr_i[RS1_LO +: RW];
  assign rd_o         = instr_i[RW-1:0];
  // stores and zero-branches read the data/test register through port 2
  assign rs2_o        = ctrl.reg2_sel ? instr_i[RW-1:0] : instr_i[RM_LO +: RW];
  assign reg_write_o  = ctrl.reg_write;
  assign mem_read_o   = ctrl.mem_read;
  assign mem_write_o  = ctrl.mem_write;
  assign mem_to_reg_o = ctrl.mem_to_reg;
  assign alu_src_o    = ctrl.alu_src;
  assign alu_op_o     = ctrl.alu_op;
  assign branch_o     = ctrl.branch;
  assign uncond_o     = ctrl.uncond;
  assign reg2_sel_o   = ctrl.reg2_sel;

  always_comb begin
    AST_IDLE_QUIET: assert (cls != CL_NONE || !(reg_write_o || mem_read_o || mem_write_o || branch_o || uncond_o)); // R8
    AST_STORE_RS2: assert (!mem_write_o || rs2_o == instr_i[RW-1:0]); // R3
    AST_CBR_RS2: assert (!branch_o || rs2_o == instr_i[RW-1:0]); // R4
    AST_IMM_ZERO: assert (cls != CL_ALU || imm_o == '0); // R7
  end
endmodule

// File: tb/instr_decoder_test.sv
module instr_decoder_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr;
  logic [4:0]  rs1, rs2, rd;
  logic [63:0] imm;
  logic        rw, mr, mw, m2r, asrc, br, ub, r2s;
  logic [3:0]  aop;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  instr_decoder uut (
    .instr_i(instr), .rs1_o(rs1), .rs2_o(rs2), .rd_o(rd), .imm_o(imm),
    .reg_write_o(rw), .mem_read_o(mr), .mem_write_o(mw), .mem_to_reg_o(m2r),
    .alu_src_o(asrc), .alu_op_o(aop), .branch_o(br), .uncond_o(ub),
    .reg2_sel_o(r2s)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp,
                     input logic [31:0] w);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s word=%h actual=%h expected=%h", req, w, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [31:0] v, input int wd);
    logic [63:0] r;
    r = 64'(v) & ((64'd1 << wd) - 64'd1);
    if (v[wd-1]) r = r | ~((64'd1 << wd) - 64'd1);
    return r;
  endfunction

  // apply word, sample after settling, compare with model built from R1..R10
  task automatic run(input logic [31:0] w);
    logic [11:0] ectl;
    logic [63:0] eimm;
    logic [4:0]  ers2;
    string       req;
    @(negedge clk);
    instr = w;
    #1;
    ectl = 12'b0; eimm = 64'd0; ers2 = w[20:16]; req = "R8";
    case (w[31:21])
      11'b10001011000: begin ectl = {8'b1000_0000, 4'b0010}; req = "R1"; end
      11'b11001011000: begin ectl = {8'b1000_0000, 4'b0110}; req = "R1"; end
      11'b10001010000: begin ectl = {8'b1000_0000, 4'b0000}; req = "R1"; end
      11'b10101010000: begin ectl = {8'b1000_0000, 4'b0001}; req = "R1"; end
      11'b11111000010: begin ectl = {8'b1101_1000, 4'b0010}; eimm = sx(w >> 12, 9); req = "R2"; end
      11'b11111000000: begin ectl = {8'b0010_1001, 4'b0010}; eimm = sx(w >> 12, 9); ers2 = w[4:0]; req = "R3"; end
      default: begin
        if (w[31:24] == 8'b10110100) begin
          ectl = {8'b0000_0101, 4'b0111}; eimm = sx(w >> 5, 19); ers2 = w[4:0]; req = "R4";
        end else if (w[31:26] == 6'b000101) begin
          ectl = {8'b0000_0010, 4'b0000}; eimm = sx(w, 26); req = "R5";
        end
      end
    endcase
    chk({req, "/R10 ctrl"}, 64'({rw, mr, mw, m2r, asrc, br, ub, r2s, aop}), 64'(ectl), w);
    chk({req, "/R7 imm"}, imm, eimm, w);
    chk("R6 rs1/rd", 64'({rs1, rd}), 64'({w[9:5], w[4:0]}), w);
    chk({req, "/R6 rs2"}, 64'(rs2), 64'(ers2), w);
    chk("R9 excl", 64'({mr & mw, br & ub}), 64'd0, w);
  endtask

  initial begin
    logic [31:0] ops [8];
    int          plen [8];
    ops[0] = 32'hF8400000; plen[0] = 11;
    ops[1] = 32'hF8000000; plen[1] = 11;
    ops[2] = 32'h8B000000; plen[2] = 11;
    ops[3] = 32'hCB000000; plen[3] = 11;
    ops[4] = 32'h8A000000; plen[4] = 11;
    ops[5] = 32'hAA000000; plen[5] = 11;
    ops[6] = 32'hB4000000; plen[6] = 8;
    ops[7] = 32'h14000000; plen[7] = 6;
    instr = 32'd0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    chk("R8 reset idle", 64'({rw, mr, mw, br, ub, aop}), 64'd0, instr);
    // known encodings
    run(32'hF8401143);
    chk("R2 ref load", 64'({rd, rs1, imm[7:0]}), 64'({5'd3, 5'd10, 8'd1}), instr);
    run(32'hCB020064);
    chk("R1 ref sub", 64'({rd, rs1, rs2, aop}), 64'({5'd4, 5'd3, 5'd2, 4'b0110}), instr);
    run(32'hB4000040);
    chk("R4 ref cbz", 64'({rs2, imm[7:0]}), 64'({5'd0, 8'd2}), instr);
    // opcode sweep under varied payloads
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < 256; p++) begin
        logic [31:0] mask, pay;
        mask = ~(32'hFFFFFFFF >> plen[k]);
        pay  = (p == 255) ? 32'hFFFFFFFF : (p * 32'h9E3779B9) ^ (p << 7);
        run((ops[k] & mask) | (pay & ~mask));
      end
    end
    // single-bit prefix misses
    for (int k = 0; k < 8; k++) begin
      for (int b = 0; b < plen[k]; b++) begin
        run(ops[k] ^ (32'h80000000 >> b) ^ 32'h00012345);
        run(ops[k] ^ (32'h80000000 >> b) ^ 32'h03FFFFFF);
      end
    end
    // scattered words
    for (int p = 0; p < 512; p++) run(p * 32'h85EBCA6B + p);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule